// File: doc/BRIEF.md
# Term Frequency Counter with Parallel-Match Table

This block counts how often each distinct term turns up in a stream of fixed-width binary keys. A term can be packed text or any other key pattern. Every stored term sits in a table that is searched in parallel. Each row of the table has a companion row in a separate count memory, and the one-hot match vector from the search selects that row. When a presented term is already in the table, its count is read, incremented and written back to the same row. When the term is new, it is placed in the lowest free row with a count of one. No hashing is involved, so no collision handling is needed.

A producer feeds terms over a valid/ready handshake. Each term finishes its read-modify-write before the next one is taken, so repeated identical terms are all counted. A full table and a saturated counter each raise a sticky flag, so a lost update is never silent. The owner can then drain the table through a sequential readout stream and merge the contents elsewhere. A single-cycle clear empties the table for the next batch.

Top module: `tfc_counter`

## Requirements
- R1: After reset, `term_ready` is 1, `dump_valid` is 0, and `table_full`, `table_ovf` and `count_sat` are 0.
- R2: A term is taken on a clock edge where `term_valid` and `term_ready` are both 1. `term_ready` is 0 in the cycle that follows, and returns to 1 one cycle later if nothing else is pending. At most one term is taken every two cycles.
- R3: A term that is not in the table goes into the lowest unused row with a count of 1. The readout stream lists rows in ascending order, which is insertion order.
- R4: A term that matches a stored row increments that row's count by exactly 1. Identical terms presented back to back are each counted.
- R5: Counts are `CNT_W` bits wide (8 by default) and stop at all-ones (255). A hit on a row already at 255 leaves it at 255 and sets the sticky `count_sat` flag.
- R6: `table_full` is 1 exactly when all `DEPTH` rows (1024 by default) hold terms.
- R7: A new term that arrives while the table is full is discarded and sets the sticky `table_ovf` flag. Stored terms and counts do not change. Hits on stored terms are still counted.
- R8: `clear` empties the table in one cycle and resets both sticky flags. It aborts an update or readout in progress, and no term is taken in a cycle where `clear` is 1.
- R9: A `dump_start` pulse in an idle cycle with at least one stored row starts a readout. `dump_valid` is held with `dump_key` and `dump_count` for row 0 upward, and the stream advances on each edge where `dump_ready` is 1. `dump_last` marks the final row. No term is taken while a readout runs. A `dump_start` with an empty table is ignored.
- R10: All `KEY_W` bits (30 by default) take part in the match, so keys that differ only in their top bit are counted separately.
- R11: When `dump_start` and `term_valid` are both high in the same idle cycle and the table is not empty, the readout wins: `term_ready` is 0 and the term waits until the readout ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Empty the table and reset the sticky flags |
| term_valid | input | 1 | A term is presented |
| term_ready | output | 1 | Block can take a term this cycle |
| term_key | input | KEY_W | Term key |
| dump_start | input | 1 | Request a readout of all stored rows |
| dump_valid | output | 1 | Readout entry is valid |
| dump_ready | input | 1 | Consumer takes the readout entry |
| dump_key | output | KEY_W | Key of the current readout entry |
| dump_count | output | CNT_W | Count of the current readout entry |
| dump_last | output | 1 | Current readout entry is the final row |
| table_full | output | 1 | Every row is in use |
| table_ovf | output | 1 | Sticky: a new term was discarded because the table was full |
| count_sat | output | 1 | Sticky: a hit found its count already at the maximum |

## Verification
Two pairs of functions can land in the same cycle here. The first pair is a clear and a pending read-modify-write. The bench provokes it by raising `clear` in the update cycle directly after a term is taken. It then judges the result at the ports: the flags must read zero, an empty-table readout request must produce nothing, and a fresh copy of the same term must read back with a count of 1. The second pair is a readout request and a term offer made on the same edge. The bench checks that `term_ready` drops and that the readout holds the table as it stood before that term. The term must be counted only after `dump_last` has been taken.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_UPDATE = 2'd1,
    ST_DUMP   = 2'd2
  } tfc_state_e;
endpackage

// File: rtl/tfc_key_cam.sv
// Parallel-match key table with per-row valid bits and a fill pointer.
module tfc_key_cam #(
  parameter int DEPTH  = 1024,
  parameter int KEY_W  = 30,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [KEY_W-1:0]  srch_key,
  input  logic              ins_en,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [FILL_W-1:0] fill_cnt,
  output logic              full,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [KEY_W-1:0]  rd_key
);
  logic [DEPTH-1:0]  valid_q, valid_d;
  logic [DEPTH-1:0]  match;
  logic [KEY_W-1:0]  key_mem [DEPTH];
  logic [FILL_W-1:0] fill_q, fill_d;
  logic [IDX_W-1:0]  ins_idx;
  logic              ins_go;

  assign ins_idx = fill_q[IDX_W-1:0];
  assign full    = (fill_q == FILL_W'(DEPTH));
  assign ins_go  = ins_en && !full && !clr;

  // compare every row at once
  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    assign match[g] = valid_q[g] && (key_mem[g] == srch_key);
  end

  assign hit = |match;

  // rows are unique, so OR-ing row numbers encodes the single match
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_idx = hit_idx | (match[i] ? IDX_W'(i) : '0);
    end
  end

  always_comb begin
    valid_d = valid_q;
    fill_d  = fill_q;
    if (clr) begin
      valid_d = '0;
      fill_d  = '0;
    end else if (ins_go) begin
      valid_d[ins_idx] = 1'b1;
      fill_d           = fill_q + FILL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      fill_q  <= '0;
    end else begin
      valid_q <= valid_d;
      fill_q  <= fill_d;
    end
  end

  // storage rows carry no reset; validity is tracked separately
  always_ff @(posedge clk) begin
    if (ins_go) key_mem[ins_idx] <= srch_key;
  end

  assign fill_cnt = fill_q;
  assign rd_key   = key_mem[rd_idx];

  // R3: a term is never held in two rows
  p_match_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  // R6: fill pointer stays within the table
  p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_W'(DEPTH));
  // R7: an insertion request never targets a full table
  p_ins_not_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !full);
endmodule

// File: rtl/tfc_count_mem.sv
// Count rows; one write port for the update, two read ports (update, readout).
module tfc_count_mem #(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [CNT_W-1:0] rd_a_cnt,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [CNT_W-1:0] rd_b_cnt
);
  logic [CNT_W-1:0] cnt_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cnt_mem[wr_idx] <= wr_cnt;
  end

  assign rd_a_cnt = cnt_mem[rd_a_idx];
  assign rd_b_cnt = cnt_mem[rd_b_idx];

  // R5: a saturating count never wraps to zero on write-back
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_cnt != '0);
endmodule

// File: rtl/tfc_dump_seq.sv
// Walks rows 0..fill-1 for the readout stream.
module tfc_dump_seq #(
  parameter int DEPTH  = 1024,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic [FILL_W-1:0] fill_cnt,
  input  logic              ready,
  output logic              active,
  output logic [IDX_W-1:0]  idx,
  output logic              last,
  output logic              done
);
  logic              active_q, active_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [FILL_W-1:0] idx_ext;

  assign idx_ext = FILL_W'(idx_q);
  assign last    = active_q && ((idx_ext + FILL_W'(1)) == fill_cnt);
  assign done    = active_q && ready && last;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    if (clr) begin
      active_d = 1'b0;
      idx_d    = '0;
    end else if (start) begin
      active_d = 1'b1;
      idx_d    = '0;
    end else if (active_q && ready) begin
      if (last) active_d = 1'b0;
      else      idx_d    = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
    end
  end

  assign active = active_q;
  assign idx    = idx_q;

  // R9: a stalled entry holds its position
  p_dump_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !ready && !clr |=> active_q && $stable(idx_q));
  // R9: the walk stays within the stored rows
  p_dump_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> idx_ext < fill_cnt);
endmodule

// File: rtl/tfc_counter.sv
module tfc_counter
  import tfc_pkg::*;
#(
  parameter int KEY_W = 30,
  parameter int DEPTH = 1024,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             term_valid,
  output logic             term_ready,
  input  logic [KEY_W-1:0] term_key,
  input  logic             dump_start,
  output logic             dump_valid,
  input  logic             dump_ready,
  output logic [KEY_W-1:0] dump_key,
  output logic [CNT_W-1:0] dump_count,
  output logic             dump_last,
  output logic             table_full,
  output logic             table_ovf,
  output logic             count_sat
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  tfc_state_e        state_q, state_d;
  logic [KEY_W-1:0]  key_q, key_d;
  logic              sat_q, sat_d, ovf_q, ovf_d;

  logic              hit, full, ins_en, dump_go, dump_done, term_take, upd;
  logic [IDX_W-1:0]  hit_idx, seq_idx, wr_idx;
  logic [FILL_W-1:0] fill_cnt;
  logic [CNT_W-1:0]  cur_cnt, wr_cnt;
  logic              wr_en, sat_set, ovf_set, fill_nz;

  assign fill_nz    = (fill_cnt != '0);
  assign dump_go    = (state_q == ST_IDLE) && !clear && dump_start && fill_nz;
  assign term_ready = (state_q == ST_IDLE) && !clear && !(dump_start && fill_nz);
  assign term_take  = term_valid && term_ready;
  assign upd        = (state_q == ST_UPDATE) && !clear;

  tfc_key_cam #(.DEPTH(DEPTH), .KEY_W(KEY_W), .IDX_W(IDX_W), .FILL_W(FILL_W)) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clear),
    .srch_key (key_q),
    .ins_en   (ins_en),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .fill_cnt (fill_cnt),
    .full     (full),
    .rd_idx   (seq_idx),
    .rd_key   (dump_key)
  );

  tfc_count_mem #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_cnt   (wr_cnt),
    .rd_a_idx (hit_idx),
    .rd_a_cnt (cur_cnt),
    .rd_b_idx (seq_idx),
    .rd_b_cnt (dump_count)
  );

  tfc_dump_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W), .FILL_W(FILL_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clear),
    .start    (dump_go),
    .fill_cnt (fill_cnt),
    .ready    (dump_ready),
    .active   (dump_valid),
    .idx      (seq_idx),
    .last     (dump_last),
    .done     (dump_done)
  );

  // update datapath: hit -> saturating increment, miss -> insert with 1
  always_comb begin
    wr_en   = 1'b0;
    ins_en  = 1'b0;
    wr_idx  = hit_idx;
    wr_cnt  = CNT_W'(1);
    sat_set = 1'b0;
    ovf_set = 1'b0;
    if (upd) begin
      if (hit) begin
        wr_en = 1'b1;
        if (cur_cnt == CNT_MAX) begin
          wr_cnt  = cur_cnt;
          sat_set = 1'b1;
        end else begin
          wr_cnt = cur_cnt + CNT_W'(1);
        end
      end else if (!full) begin
        wr_en  = 1'b1;
        ins_en = 1'b1;
        wr_idx = fill_cnt[IDX_W-1:0];
      end else begin
        ovf_set = 1'b1;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    key_d   = key_q;
    if (clear) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (dump_go) begin
            state_d = ST_DUMP;
          end else if (term_take) begin
            state_d = ST_UPDATE;
            key_d   = term_key;
          end
        end
        ST_UPDATE: state_d = ST_IDLE;
        ST_DUMP:   if (dump_done) state_d = ST_IDLE;
        default:   state_d = ST_IDLE;
      endcase
    end
    sat_d = clear ? 1'b0 : (sat_q | sat_set);
    ovf_d = clear ? 1'b0 : (ovf_q | ovf_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      key_q   <= '0;
      sat_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      key_q   <= key_d;
      sat_q   <= sat_d;
      ovf_q   <= ovf_d;
    end
  end

  assign table_full = full;
  assign table_ovf  = ovf_q;
  assign count_sat  = sat_q;

  // R2: a taken term blocks the next offer for one cycle
  p_ready_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    term_take |=> !term_ready);
  // R5: saturation flag is sticky until clear
  p_sat_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count_sat && !clear |=> count_sat);
  // R7: overflow flag is sticky and only rises with a full table
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    table_ovf && !clear |=> table_ovf);
  p_ovf_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(table_ovf) |-> table_full);
  // R8: clear empties everything in one cycle
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !table_full && !table_ovf && !count_sat && !dump_valid);
  // R9: no term is taken during a readout
  p_no_take_dump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dump_valid |-> !term_ready);
  // R11: a readout never begins on an edge that also took a term
  p_dump_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dump_valid) |-> !$past(term_valid && term_ready));
endmodule

// File: tb/tfc_counter_bench.sv
module tfc_counter_bench;
  localparam int KEY_W = 30;
  localparam int DEPTH = 8;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n, clear, term_valid, dump_start, dump_ready;
  logic [KEY_W-1:0] term_key;
  logic             term_ready, dump_valid, dump_last, table_full, table_ovf, count_sat;
  logic [KEY_W-1:0] dump_key;
  logic [CNT_W-1:0] dump_count;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // reference model
  logic [KEY_W-1:0] m_key [$];
  int               m_cnt [$];
  bit               m_sat = 0, m_ovf = 0;

  // scoreboard for the readout stream
  logic [KEY_W-1:0] exp_key [$];
  int               exp_cnt [$];
  bit               exp_last [$];
  string            dump_tag = "R3";

  always #5 clk = ~clk;

  tfc_counter #(.KEY_W(KEY_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_tfc_counter (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .term_valid(term_valid), .term_ready(term_ready), .term_key(term_key),
    .dump_start(dump_start), .dump_valid(dump_valid), .dump_ready(dump_ready),
    .dump_key(dump_key), .dump_count(dump_count), .dump_last(dump_last),
    .table_full(table_full), .table_ovf(table_ovf), .count_sat(count_sat)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model_apply(logic [KEY_W-1:0] k);
    int idx = -1;
    foreach (m_key[i]) if (m_key[i] == k) idx = i;
    if (idx >= 0) begin
      if (m_cnt[idx] < 255) m_cnt[idx]++;
      else m_sat = 1;
    end else if (m_key.size() < DEPTH) begin
      m_key.push_back(k);
      m_cnt.push_back(1);
    end else begin
      m_ovf = 1;
    end
  endfunction

  function automatic void load_expect();
    foreach (m_key[i]) begin
      exp_key.push_back(m_key[i]);
      exp_cnt.push_back(m_cnt[i]);
      exp_last.push_back(i == m_key.size() - 1);
    end
  endfunction

  // monitor: compares each readout transfer with the scoreboard
  always @(negedge clk) begin
    if (rst_n && dump_valid && term_ready) begin
      checks++; fails++;
      $display("FAIL R9 term_ready during readout: actual 1 expected 0");
    end
    if (rst_n && dump_valid && dump_ready) begin
      if (exp_key.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected readout entry: actual key %0h expected none", dump_key);
      end else begin
        logic [KEY_W-1:0] ek;
        int ec;
        bit el;
        ek = exp_key.pop_front();
        ec = exp_cnt.pop_front();
        el = exp_last.pop_front();
        check(dump_tag, 64'(dump_key), 64'(ek), "readout key");
        check(dump_tag, 64'(dump_count), 64'(ec), "readout count");
        check("R9", 64'(dump_last), 64'(el), "readout last marker");
      end
    end
  end

  // driver: offers one term and updates the model when it is taken
  task automatic send_term(logic [KEY_W-1:0] k);
    @(posedge clk); #1;
    term_valid = 1'b1;
    term_key   = k;
    do @(negedge clk); while (!term_ready);
    @(posedge clk); #1;
    term_valid = 1'b0;
    model_apply(k);
    @(negedge clk);
    check("R2", 64'(term_ready), 64'd0, "ready after take");
  endtask

  task automatic check_flags(string req);
    @(posedge clk); #1;
    @(negedge clk);
    check(req, 64'(table_full), 64'(m_key.size() == DEPTH), "table_full");
    check(req, 64'(table_ovf), 64'(m_ovf), "table_ovf");
    check(req, 64'(count_sat), 64'(m_sat), "count_sat");
  endtask

  task automatic do_dump(bit stall, string tag);
    int guard = 0;
    dump_tag = tag;
    load_expect();
    @(posedge clk); #1;
    dump_ready = !stall;
    dump_start = 1'b1;
    @(posedge clk); #1;
    dump_start = 1'b0;
    while (exp_key.size() > 0 && guard < 2000) begin
      @(posedge clk); #1;
      if (stall) dump_ready = ~dump_ready;
      guard++;
    end
    dump_ready = 1'b1;
    @(negedge clk);
    check("R9", 64'(exp_key.size()), 64'd0, "entries left unread");
    check("R9", 64'(dump_valid), 64'd0, "valid after final entry");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clear = 1'b0; term_valid = 1'b0; term_key = '0;
    dump_start = 1'b0; dump_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", 64'(term_ready), 64'd1, "term_ready");
    check("R1", 64'(dump_valid), 64'd0, "dump_valid");
    check("R1", 64'(table_full), 64'd0, "table_full");
    check("R1", 64'(table_ovf), 64'd0, "table_ovf");
    check("R1", 64'(count_sat), 64'd0, "count_sat");

    // R3 inserts, R4 hits incl. back-to-back, R10 top-bit distinct keys
    send_term(30'h0000_0123);
    send_term(30'h0ABC_0001);
    send_term(30'h0000_0123);
    send_term(30'h0000_0123);
    send_term(30'h2000_0123);
    send_term(30'h3FFF_FFFF);
    send_term(30'h0ABC_0001);
    check_flags("R6");
    do_dump(1'b0, "R4");

    // R11 readout and term offered on the same edge
    load_expect();
    dump_tag = "R11";
    @(posedge clk); #1;
    dump_start = 1'b1; term_valid = 1'b1; term_key = 30'h0000_0777; dump_ready = 1'b1;
    @(negedge clk);
    check("R11", 64'(term_ready), 64'd0, "ready with readout request");
    @(posedge clk); #1;
    dump_start = 1'b0;
    while (exp_key.size() > 0) begin @(posedge clk); #1; end
    do @(negedge clk); while (!term_ready);
    @(posedge clk); #1;
    term_valid = 1'b0;
    model_apply(30'h0000_0777);

    // R9 readout with a stalling consumer; also shows the R11 term landed last
    do_dump(1'b1, "R11");

    // R5 saturation
    for (int i = 0; i < 257; i++) send_term(30'h1555_5555);
    check_flags("R5");
    do_dump(1'b0, "R5");

    // R6 fill to capacity, R7 overflow
    send_term(30'h0000_0A01);
    send_term(30'h0000_0A02);
    check_flags("R6");
    send_term(30'h0000_0B00);
    check_flags("R7");
    send_term(30'h0000_0123);
    do_dump(1'b0, "R7");

    // R8 clear colliding with an update in flight
    @(posedge clk); #1;
    term_valid = 1'b1; term_key = 30'h0000_0123;
    do @(negedge clk); while (!term_ready);
    @(posedge clk); #1;
    term_valid = 1'b0;
    clear = 1'b1;
    @(negedge clk);
    check("R8", 64'(term_ready), 64'd0, "ready while clear");
    @(posedge clk); #1;
    clear = 1'b0;
    m_key.delete(); m_cnt.delete(); m_sat = 0; m_ovf = 0;
    check_flags("R8");
    // R9 readout request on an empty table is ignored
    @(posedge clk); #1;
    dump_start = 1'b1;
    @(posedge clk); #1;
    dump_start = 1'b0;
    @(negedge clk);
    check("R9", 64'(dump_valid), 64'd0, "empty-table readout");
    check("R8", 64'(term_ready), 64'd1, "ready after clear");
    send_term(30'h0000_0123);
    do_dump(1'b0, "R8");

    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule